// File: doc/BRIEF.md
# Two-Entry Monitor Lock Cache

This block keeps a small hardware cache of object monitor locks for a processor's execute stage. It has two entries. Each entry holds the address of a locked object, a recursion count and a "wanted" flag. The wanted flag means another thread is waiting for the lock.

A lock request carries an object address and a direction: enter or exit. The block compares the address against both entries in one cycle.

- **Enter hit:** the count on the matching entry goes up by one.
- **Exit hit:** the count goes down by one.
- **Exception conditions:** the block reports one of them instead of the plain update. These are a null reference, a miss on both entries, a count about to wrap in either direction, and the last exit from a lock that another thread wants.

Privileged software loads each entry's address and count through a write port and reads them back through a read port. It uses the reported condition to run the matching trap handler.

The outcome code is registered. It appears on `exc_code` and `exc_entry` in the cycle after the request edge and stays there for one cycle only. The count update takes effect at that same edge.

Outcome codes on `exc_code`:

| Code | Meaning |
|------|---------|
| 0 | none |
| 1 | null reference |
| 2 | miss |
| 3 | overflow |
| 4 | underflow |
| 5 | release |

Top module: `lock_cache`

## Requirements
- R1: After reset, `exc_code` is 0 and every address and count register reads 0.
- R2: A write with `wr_cnt_sel`=0 loads the low `ADDR_W` bits of `wr_data` into the chosen entry's address. A write with `wr_cnt_sel`=1 loads the count from `wr_data[CNT_W-1:0]` and the wanted flag from `wr_data[WANT_BIT]`. Both take effect at the next edge. A count read returns the count in bits `CNT_W-1:0` and the wanted flag in bit `WANT_BIT`, with 0 elsewhere. An address read returns the address zero-extended.
- R3: An enter request that hits an entry whose count is below 2^`CNT_W`-1 increments that count and reports code 0.
- R4: An exit request that hits an entry with a non-zero count decrements it. It reports code 0 unless R7 applies.
- R5: An enter request that hits an entry at count 2^`CNT_W`-1 reports code 3 with `exc_entry` naming the entry, and leaves the count unchanged. `exc_entry` is 0 for every code other than 3, 4 and 5.
- R6: An exit request that hits an entry at count 0 reports code 4 with `exc_entry` naming the entry, and leaves the count unchanged.
- R7: An exit request that hits an entry at count 1 whose wanted flag is 1 decrements the count to 0 and reports code 5 with `exc_entry` naming the entry. Requests never change the wanted flag.
- R8: A request with a non-zero address that matches neither entry reports code 2 and changes no count.
- R9: A request with address 0 reports code 1 and changes no count, even when an entry holds address 0.
- R10: With `req_valid` low, the next outcome is code 0 and no count changes.
- R11: When both entries hold the requested address, only entry 0 is used and updated.
- R12: A count write to an entry in the same cycle as a request that would update that entry wins. The written value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lock request valid (execute-stage instruction valid) |
| req_exit | input | 1 | 1 = exit request, 0 = enter request |
| req_addr | input | ADDR_W | Object address of the request |
| wr_en | input | 1 | Privileged register write strobe |
| wr_idx | input | 1 | Entry selected for the write |
| wr_cnt_sel | input | 1 | 1 = count register, 0 = address register |
| wr_data | input | DATA_W | Write data |
| rd_idx | input | 1 | Entry selected for the read |
| rd_cnt_sel | input | 1 | 1 = count register, 0 = address register |
| rd_data | output | DATA_W | Read data (combinational) |
| exc_code | output | 3 | Registered outcome code (0 none, 1 null, 2 miss, 3 overflow, 4 underflow, 5 release) |
| exc_entry | output | 1 | Entry index for codes 3, 4 and 5; 0 otherwise |

## Verification
The bench builds the block with a 6-bit address, a 16-bit register width, a 3-bit count and the wanted flag at bit 14. The 3-bit count saturates at 7, so every count value can be swept for both directions, both wanted settings and both entries. The 6-bit address means all 64 request addresses can be tried against the loaded entries. Together these reach every pair of boundaries: overflow, underflow, release and miss. Separate cases cover both entries holding the same address, an entry holding the null address, and a count write colliding with a request.

// File: rtl/lockc_pkg.sv
package lockc_pkg;

    typedef enum logic [2:0] {
        EXC_NONE = 3'd0,
        EXC_NULL = 3'd1,
        EXC_MISS = 3'd2,
        EXC_OVF  = 3'd3,
        EXC_UNF  = 3'd4,
        EXC_REL  = 3'd5
    } lk_exc_e;

    typedef enum logic [2:0] {
        CLS_IDLE,
        CLS_NULL,
        CLS_MISS,
        CLS_ENTER,
        CLS_EXIT
    } lk_cls_e;

endpackage

// File: rtl/lockc_entry.sv
module lockc_entry #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 8,
    parameter int WANT_BIT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr_en,
    input  logic              wr_cnt_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              upd_en,
    input  logic [CNT_W-1:0]  upd_cnt,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              match,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              want_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            want_q <= 1'b0;
        end else begin
            if (wr_addr_en) begin
                addr_q <= wr_data[ADDR_W-1:0];
            end
            if (wr_cnt_en) begin
                cnt_q  <= wr_data[CNT_W-1:0];
                want_q <= wr_data[WANT_BIT];
            end else if (upd_en) begin
                cnt_q <= upd_cnt;
            end
        end
    end

    always_comb begin
        match = (addr_q == lookup_addr);
    end

endmodule

// File: rtl/lockc_resolve.sv
module lockc_resolve
    import lockc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             req_valid,
    input  logic             req_exit,
    input  logic             addr_null,
    input  logic [1:0]       match,
    input  logic [CNT_W-1:0] cnt0,
    input  logic [CNT_W-1:0] cnt1,
    input  logic [1:0]       want,
    output lk_exc_e          code,
    output logic             entry,
    output logic [1:0]       upd_en,
    output logic [CNT_W-1:0] upd_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    lk_cls_e          cls;
    logic             sel;
    logic [CNT_W-1:0] cur;
    logic             cur_want;

    // Entry 0 wins when both hold the address.
    always_comb begin
        sel      = ~match[0];
        cur      = sel ? cnt1 : cnt0;
        cur_want = want[sel];
    end

    always_comb begin
        if (!req_valid)       cls = CLS_IDLE;
        else if (addr_null)   cls = CLS_NULL;
        else if (match == 2'b00) cls = CLS_MISS;
        else if (req_exit)    cls = CLS_EXIT;
        else                  cls = CLS_ENTER;
    end

    always_comb begin
        code    = EXC_NONE;
        entry   = 1'b0;
        upd_en  = 2'b00;
        upd_cnt = cur;
        unique case (cls)
            CLS_IDLE: begin
                code = EXC_NONE;
            end
            CLS_NULL: begin
                code = EXC_NULL;
            end
            CLS_MISS: begin
                code = EXC_MISS;
            end
            CLS_ENTER: begin
                if (cur == CNT_MAX) begin
                    code  = EXC_OVF;
                    entry = sel;
                end else begin
                    upd_cnt     = cur + CNT_ONE;
                    upd_en[sel] = 1'b1;
                end
            end
            CLS_EXIT: begin
                if (cur == '0) begin
                    code  = EXC_UNF;
                    entry = sel;
                end else begin
                    upd_cnt     = cur - CNT_ONE;
                    upd_en[sel] = 1'b1;
                    if (cur == CNT_ONE && cur_want) begin
                        code  = EXC_REL;
                        entry = sel;
                    end
                end
            end
            default: begin
                code = EXC_NONE;
            end
        endcase
    end

endmodule

// File: rtl/lock_cache.sv
module lock_cache
    import lockc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 8,
    parameter int WANT_BIT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_exit,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wr_en,
    input  logic              wr_idx,
    input  logic              wr_cnt_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_idx,
    input  logic              rd_cnt_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [2:0]        exc_code,
    output logic              exc_entry
);

    localparam int N_ENT = 2;

    logic [ADDR_W-1:0] ent_addr [N_ENT];
    logic [CNT_W-1:0]  ent_cnt  [N_ENT];
    logic [N_ENT-1:0]  ent_want;
    logic [N_ENT-1:0]  ent_match;
    logic [N_ENT-1:0]  ent_upd;
    logic [CNT_W-1:0]  upd_cnt;
    lk_exc_e           nxt_code;
    logic              nxt_entry;
    lk_exc_e           code_q;
    logic              entry_q;
    logic              addr_null;

    always_comb begin
        addr_null = (req_addr == '0);
    end

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
        logic sel_me;
        always_comb begin
            sel_me = wr_en && (wr_idx == 1'(gi));
        end
        lockc_entry #(
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .CNT_W    (CNT_W),
            .WANT_BIT (WANT_BIT)
        ) u_entry (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_addr_en  (sel_me && !wr_cnt_sel),
            .wr_cnt_en   (sel_me && wr_cnt_sel),
            .wr_data     (wr_data),
            .upd_en      (ent_upd[gi]),
            .upd_cnt     (upd_cnt),
            .lookup_addr (req_addr),
            .match       (ent_match[gi]),
            .addr_q      (ent_addr[gi]),
            .cnt_q       (ent_cnt[gi]),
            .want_q      (ent_want[gi])
        );
    end

    lockc_resolve #(
        .CNT_W (CNT_W)
    ) u_resolve (
        .req_valid (req_valid),
        .req_exit  (req_exit),
        .addr_null (addr_null),
        .match     (ent_match),
        .cnt0      (ent_cnt[0]),
        .cnt1      (ent_cnt[1]),
        .want      (ent_want),
        .code      (nxt_code),
        .entry     (nxt_entry),
        .upd_en    (ent_upd),
        .upd_cnt   (upd_cnt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= EXC_NONE;
            entry_q <= 1'b0;
        end else begin
            code_q  <= nxt_code;
            entry_q <= nxt_entry;
        end
    end

    always_comb begin
        exc_code  = code_q;
        exc_entry = entry_q;
    end

    always_comb begin
        rd_data = '0;
        if (rd_cnt_sel) begin
            rd_data[CNT_W-1:0] = ent_cnt[rd_idx];
            rd_data[WANT_BIT]  = ent_want[rd_idx];
        end else begin
            rd_data[ADDR_W-1:0] = ent_addr[rd_idx];
        end
    end

endmodule

// File: rtl/lock_cache_chk.sv
module lock_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              wr_en,
    input logic              wr_cnt_sel,
    input logic [2:0]        exc_code,
    input logic              exc_entry,
    input logic [CNT_W-1:0]  cnt0,
    input logic [CNT_W-1:0]  cnt1
);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> exc_code == 3'd0);

    // R9
    null_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr == '0) |=> exc_code == 3'd1);

    // R8
    frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((exc_code >= 3'd1 && exc_code <= 3'd4) && !$past(wr_en && wr_cnt_sel))
        |-> ($stable(cnt0) && $stable(cnt1)));

    // R7
    release_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_code == 3'd5 && !$past(wr_en && wr_cnt_sel))
        |-> ((exc_entry ? cnt1 : cnt0) == '0));

    // R5
    entry_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_code < 3'd3) |-> exc_entry == 1'b0);

    // R5
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_code <= 3'd5);

endmodule

bind lock_cache lock_cache_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_lock_cache_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .wr_en      (wr_en),
    .wr_cnt_sel (wr_cnt_sel),
    .exc_code   (exc_code),
    .exc_entry  (exc_entry),
    .cnt0       (ent_cnt[0]),
    .cnt1       (ent_cnt[1])
);

// File: tb/test_lock_cache.sv
`timescale 1ns/1ps
module test_lock_cache;

    localparam int AW   = 6;
    localparam int DW   = 16;
    localparam int CW   = 3;
    localparam int WB   = 14;
    localparam int MAXC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_exit = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          wr_en = 1'b0;
    logic          wr_idx = 1'b0;
    logic          wr_cnt_sel = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_idx = 1'b0;
    logic          rd_cnt_sel = 1'b0;
    logic [DW-1:0] rd_data;
    logic [2:0]    exc_code;
    logic          exc_entry;

    int checks = 0;
    int errors = 0;
    int m_addr [2];
    int m_cnt  [2];
    int m_want [2];

    always #4 clk = ~clk;

    lock_cache #(
        .ADDR_W   (AW),
        .DATA_W   (DW),
        .CNT_W    (CW),
        .WANT_BIT (WB)
    ) i_lock_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_exit   (req_exit),
        .req_addr   (req_addr),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_cnt_sel (wr_cnt_sel),
        .wr_data    (wr_data),
        .rd_idx     (rd_idx),
        .rd_cnt_sel (rd_cnt_sel),
        .rd_data    (rd_data),
        .exc_code   (exc_code),
        .exc_entry  (exc_entry)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic readback(input string tag);
        for (int i = 0; i < 2; i++) begin
            int exp;
            rd_idx = 1'(i);
            rd_cnt_sel = 1'b1;
            #1;
            exp = (m_want[i] << WB) | m_cnt[i];
            chk(int'(rd_data) == exp, tag, int'(rd_data), exp);
            rd_cnt_sel = 1'b0;
            #1;
            chk(int'(rd_data) == m_addr[i], tag, int'(rd_data), m_addr[i]);
        end
    endtask

    task automatic wr(input int idx, input bit csel, input int data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_idx = 1'(idx);
        wr_cnt_sel = csel;
        wr_data = DW'(data);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        if (csel) begin
            m_cnt[idx]  = data & MAXC;
            m_want[idx] = (data >> WB) & 1;
        end else begin
            m_addr[idx] = data & ((1 << AW) - 1);
        end
    endtask

    // Reference outcome computed from the requirements.
    task automatic predict(input bit v, input bit ex, input int a,
                           output int code, output int ent, output int sel,
                           output int ncnt, output string tag);
        bit h0, h1;
        h0 = (m_addr[0] == a);
        h1 = (m_addr[1] == a);
        code = 0; ent = 0; sel = -1; ncnt = 0;
        if (!v) begin
            tag = "R10";
        end else if (a == 0) begin
            code = 1; tag = "R9";
        end else if (!h0 && !h1) begin
            code = 2; tag = "R8";
        end else begin
            int s;
            s = h0 ? 0 : 1;
            if (!ex) begin
                if (m_cnt[s] == MAXC) begin
                    code = 3; ent = s; tag = "R5";
                end else begin
                    sel = s; ncnt = m_cnt[s] + 1; tag = "R3";
                end
            end else begin
                if (m_cnt[s] == 0) begin
                    code = 4; ent = s; tag = "R6";
                end else begin
                    sel = s; ncnt = m_cnt[s] - 1; tag = "R4";
                    if (m_cnt[s] == 1 && m_want[s] == 1) begin
                        code = 5; ent = s; tag = "R7";
                    end
                end
            end
        end
    endtask

    task automatic req(input bit v, input bit ex, input int a, input string force_tag);
        int code, ent, sel, ncnt;
        string tag;
        predict(v, ex, a, code, ent, sel, ncnt, tag);
        if (force_tag != "") tag = force_tag;
        @(negedge clk);
        req_valid = v;
        req_exit = ex;
        req_addr = AW'(a);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(int'(exc_code) == code, tag, int'(exc_code), code);
        chk(int'(exc_entry) == ent, tag, int'(exc_entry), ent);
        if (sel >= 0) m_cnt[sel] = ncnt;
        readback(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(exc_code == 3'd0, "R1", int'(exc_code), 0);
        m_addr = '{0, 0}; m_cnt = '{0, 0}; m_want = '{0, 0};
        readback("R1");

        // R2 field placement and masking of unused write bits
        wr(0, 1'b0, 16'hFFC5);
        wr(1, 1'b0, 16'h0009);
        wr(0, 1'b1, 16'hBEEF);
        wr(1, 1'b1, 16'h0F02);
        readback("R2");
        wr(0, 1'b0, 5);

        // Sweep every count, wanted flag, direction and entry (R3 R4 R5 R6 R7)
        for (int e = 0; e < 2; e++) begin
            for (int w = 0; w < 2; w++) begin
                for (int c = 0; c <= MAXC; c++) begin
                    for (int ex = 0; ex < 2; ex++) begin
                        wr(e, 1'b1, (w << WB) | c);
                        req(1'b1, 1'(ex), (e == 1) ? 9 : 5, "");
                    end
                end
            end
        end

        // R10 outcome returns to none after a request, and idle requests do nothing
        @(negedge clk);
        chk(exc_code == 3'd0, "R10", int'(exc_code), 0);
        req(1'b0, 1'b0, 5, "");
        req(1'b0, 1'b1, 9, "");

        // Full address sweep: null, miss and hits (R8 R9)
        wr(0, 1'b1, 3);
        wr(1, 1'b1, 4);
        for (int a = 0; a < (1 << AW); a++) begin
            req(1'b1, 1'(a & 1), a, "");
        end

        // R11 both entries hold the same address
        wr(0, 1'b0, 12);
        wr(1, 1'b0, 12);
        wr(0, 1'b1, 2);
        wr(1, 1'b1, 4);
        req(1'b1, 1'b0, 12, "R11");
        req(1'b1, 1'b1, 12, "R11");
        req(1'b1, 1'b1, 12, "R11");

        // R9 an entry holding address 0 is never hit
        wr(1, 1'b0, 0);
        req(1'b1, 1'b0, 0, "R9");

        // R12 count write collides with an updating request
        begin
            int code, ent, sel, ncnt;
            string tag;
            predict(1'b1, 1'b0, 12, code, ent, sel, ncnt, tag);
            @(negedge clk);
            wr_en = 1'b1; wr_idx = 1'b0; wr_cnt_sel = 1'b1; wr_data = 16'd6;
            req_valid = 1'b1; req_exit = 1'b0; req_addr = AW'(12);
            @(posedge clk);
            @(negedge clk);
            wr_en = 1'b0; req_valid = 1'b0;
            m_cnt[0] = 6; m_want[0] = 0;
            chk(int'(exc_code) == code, "R12", int'(exc_code), code);
            readback("R12");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1600000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule